// File: doc/BRIEF.md
# Segmented Variable-Latency Adder

This block adds two n-bit operands with a carry structure cut into m = n/k groups of k bits. Each group resolves its own carries by rippling, and a group's carry-out reaches the next group through a boundary register. The design is sized for the short carry chains that most operand pairs produce, so the common case finishes in one cycle. Rare long propagate runs take extra cycles. The longest, an all-propagate operand pair, takes m cycles.

Each bit's carry-in is tracked as resolved or unresolved. A bit whose operand bits are equal resolves the carry above it on its own: equal ones generate a carry and equal zeros kill it. A propagating bit passes on the status of the carry below it. The addition is complete when every bit's carry-in is resolved. The controller has two states. `ST_IDLE` moves to `ST_CALC` when a start is accepted. `ST_CALC` stays in `ST_CALC` while carries are still unresolved, or when a new start is accepted in the completing cycle. `ST_CALC` returns to `ST_IDLE` when the sum is complete, the external enable is high and no new start arrives.

While the sum is incomplete, the pipeline-enable output is held low so that the enclosing pipeline freezes. The external enable input is the AND of the enables of other adders in the same pipeline stage, so the stage only advances when every adder in it has finished.

Top module: `seg_carry_adder`

## Requirements
- R1: Whenever `done_o` is high, `sum_o` equals (A + B) mod 2^WIDTH for the operands captured at the last accepted start.
- R2: A start is accepted, and A and B are captured, only on a clock edge where `start_i` and `pipe_en_o` are both high. In the cycle after an accepted start, `cyc_o` is 1.
- R3: For bit i, let j be the highest position below i where the two operand bits are equal, and let its group be floor(j/k), taken as -1 when no such j exists. The latency L is the largest value of group(i) − group(j) over all bits, with a floor of 1. When L is 1 (normal mode), `done_o` is high in the first cycle after the accepted start.
- R4: When L from R3 is 2 (sub-normal mode), `done_o` is low in the first cycle and high in the second.
- R5: When L from R3 is 3 or more (extended mode), `done_o` first rises in cycle L. An all-propagate operand pair gives L = m.
- R6: While an addition is in progress and not complete, `pipe_en_o` is low. When the block is idle, or in the completing cycle, `pipe_en_o` equals `en_in_i`.
- R7: While `en_in_i` is low, `pipe_en_o` is low and no start is accepted. A completed result keeps `done_o` high and holds `sum_o` and `cyc_o` unchanged.
- R8: A start raised while an addition is incomplete is refused. The cycle count keeps advancing, and the captured operands are unchanged.
- R9: During an addition, `cyc_o` counts the cycles since the accepted start. When `done_o` is high, `mode_o` is 1 for one cycle, 2 for two cycles and 3 for more. Otherwise `mode_o` is 0.
- R10: After reset the block is idle: `done_o` = 0, `cyc_o` = 0, `mode_o` = 0 and `pipe_en_o` = `en_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to capture a_i and b_i |
| en_in_i | input | 1 | Enable from the other adders of the stage (ANDed) |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Sum, valid while done_o is high |
| done_o | output | 1 | Every bit's carry-in is resolved |
| pipe_en_o | output | 1 | Pipeline clock enable; low on stall cycles |
| cyc_o | output | clog2(WIDTH/GRP+1) | Cycles since the accepted start |
| mode_o | output | 2 | 0 none, 1 normal, 2 sub-normal, 3 extended |

## Verification
The bench tries several kinds of operand pairs, and each kind tests a different part of the latency behaviour. Random operands give mostly one-cycle sums and check the basic sum. Equal operands resolve every carry locally. Complementary operands give the full all-propagate worst case of m cycles. Operands that break the propagate run only at the bottom of every second group give exactly two cycles, which separates the sub-normal case from its neighbours. Complementary operands with a few random break bits spread latencies across the extended range. Directed runs test the refused start, a result held while the external enable is low, and a new start accepted in the completing cycle.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } ctl_state_t;

    typedef enum logic [1:0] {
        MD_NONE   = 2'd0,
        MD_SINGLE = 2'd1,
        MD_DOUBLE = 2'd2,
        MD_LONG   = 2'd3
    } lat_mode_t;

endpackage

// File: rtl/seg_add_group.sv
// One k-bit ripple group with a resolved/unresolved flag on every carry.
module seg_add_group #(
    parameter int GW = 8
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_k_i,
    input  logic          cin_v_i,
    output logic [GW-1:0] sum_o,
    output logic [GW-1:0] ck_o,
    output logic          cout_k_o,
    output logic          cout_v_o,
    output logic          loc_k_o,
    output logic          loc_v_o
);

    // ck/cv: carry chain using the supplied carry-in status
    // lk/lv: same chain assuming an unresolved carry-in
    logic [GW:0] ck;
    logic [GW:0] cv;
    logic [GW:0] lk;
    logic [GW:0] lv;

    assign ck[0] = cin_k_i;
    assign cv[0] = cin_v_i;
    assign lk[0] = 1'b0;
    assign lv[0] = 1'b0;

    for (genvar j = 0; j < GW; j++) begin : g_bit
        logic prop;
        assign prop      = a_i[j] ^ b_i[j];
        // an equal pair generates (1,1) or kills (0,0): carry above it is known
        assign ck[j+1]   = ~prop | ck[j];
        assign cv[j+1]   = prop ? cv[j] : a_i[j];
        assign lk[j+1]   = ~prop | lk[j];
        assign lv[j+1]   = prop ? lv[j] : a_i[j];
        assign sum_o[j]  = prop ^ cv[j];
        assign ck_o[j]   = ck[j];
    end

    assign cout_k_o = ck[GW];
    assign cout_v_o = cv[GW];
    assign loc_k_o  = lk[GW];
    assign loc_v_o  = lv[GW];

endmodule

// File: rtl/seg_add_ctrl.sv
// Start acceptance, stall generation, cycle count and mode report.
module seg_add_ctrl
    import seg_add_pkg::*;
#(
    parameter int NG = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       en_in_i,
    input  logic                       all_known_i,
    output logic                       load_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       pipe_en_o,
    output logic [$clog2(NG+1)-1:0]    cyc_o,
    output lat_mode_t                  mode_o
);

    localparam int CW = $clog2(NG + 1);

    ctl_state_t    state_q;
    ctl_state_t    state_d;
    logic [CW-1:0] cyc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the controller
    always_comb begin
        busy_o    = 1'b0;
        done_o    = 1'b0;
        pipe_en_o = 1'b0;
        mode_o    = MD_NONE;
        unique case (state_q)
            ST_IDLE: begin
                pipe_en_o = en_in_i;
            end
            ST_CALC: begin
                busy_o    = 1'b1;
                done_o    = all_known_i;
                pipe_en_o = en_in_i & all_known_i;
                if (all_known_i) begin
                    if (cyc_q == CW'(1)) begin
                        mode_o = MD_SINGLE;
                    end else if (cyc_q == CW'(2)) begin
                        mode_o = MD_DOUBLE;
                    end else begin
                        mode_o = MD_LONG;
                    end
                end
            end
        endcase
        load_o = start_i & pipe_en_o;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_o) begin
                    state_d = ST_CALC;
                end
            end
            ST_CALC: begin
                if (done_o && en_in_i && !load_o) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (load_o) begin
            cyc_q <= CW'(1);
        end else if (done_o && en_in_i) begin
            cyc_q <= '0;
        end else if (busy_o && !done_o && (cyc_q < CW'(NG))) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign cyc_o = cyc_q;

endmodule

// File: rtl/seg_carry_adder.sv
// Segmented adder: k-bit ripple groups, registered group boundaries,
// one-group lookahead, completion by per-bit carry resolution.
module seg_carry_adder
    import seg_add_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int GRP   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              en_in_i,
    input  logic [WIDTH-1:0]                  a_i,
    input  logic [WIDTH-1:0]                  b_i,
    output logic [WIDTH-1:0]                  sum_o,
    output logic                              done_o,
    output logic                              pipe_en_o,
    output logic [$clog2(WIDTH/GRP+1)-1:0]    cyc_o,
    output logic [1:0]                        mode_o
);

    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH-1:0] opa_q;
    logic [WIDTH-1:0] opb_q;
    logic [NGRP-1:1]  rk_q;
    logic [NGRP-1:1]  rv_q;

    logic [NGRP-1:0]  cin_k;
    logic [NGRP-1:0]  cin_v;
    logic [NGRP-1:0]  cout_k;
    logic [NGRP-1:0]  cout_v;
    logic [NGRP-1:0]  loc_k;
    logic [NGRP-1:0]  loc_v;
    logic [WIDTH-1:0] bit_known;
    logic             all_known;
    logic             load;
    logic             busy;
    lat_mode_t        mode_w;
    logic             unused_tail;

    // operand registers: frozen unless a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (load) begin
            opa_q <= a_i;
            opb_q <= b_i;
        end
    end

    // group carry-in: registered boundary if resolved, else the lower
    // group's locally resolved carry-out
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g == 0) begin : g_first
            assign cin_k[g] = 1'b1;
            assign cin_v[g] = 1'b0;
        end else begin : g_rest
            assign cin_k[g] = rk_q[g] | loc_k[g-1];
            assign cin_v[g] = rk_q[g] ? rv_q[g] : loc_v[g-1];
        end

        seg_add_group #(
            .GW(GRP)
        ) u_grp (
            .a_i      (opa_q[g*GRP +: GRP]),
            .b_i      (opb_q[g*GRP +: GRP]),
            .cin_k_i  (cin_k[g]),
            .cin_v_i  (cin_v[g]),
            .sum_o    (sum_o[g*GRP +: GRP]),
            .ck_o     (bit_known[g*GRP +: GRP]),
            .cout_k_o (cout_k[g]),
            .cout_v_o (cout_v[g]),
            .loc_k_o  (loc_k[g]),
            .loc_v_o  (loc_v[g])
        );
    end

    // boundary registers: one group boundary crossed per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rk_q <= '0;
            rv_q <= '0;
        end else if (load) begin
            rk_q <= '0;
            rv_q <= '0;
        end else if (busy) begin
            for (int g = 1; g < NGRP; g++) begin
                rk_q[g] <= cout_k[g-1];
                rv_q[g] <= cout_v[g-1];
            end
        end
    end

    assign all_known   = &bit_known;
    assign unused_tail = cout_k[NGRP-1] ^ cout_v[NGRP-1] ^ loc_k[NGRP-1] ^ loc_v[NGRP-1];

    seg_add_ctrl #(
        .NG(NGRP)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .en_in_i     (en_in_i),
        .all_known_i (all_known),
        .load_o      (load),
        .busy_o      (busy),
        .done_o      (done_o),
        .pipe_en_o   (pipe_en_o),
        .cyc_o       (cyc_o),
        .mode_o      (mode_w)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/seg_carry_adder_chk.sv
module seg_carry_adder_chk #(
    parameter int WIDTH = 64,
    parameter int GRP   = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              start_i,
    input logic                              en_in_i,
    input logic [WIDTH-1:0]                  sum_o,
    input logic                              done_o,
    input logic                              pipe_en_o,
    input logic [$clog2(WIDTH/GRP+1)-1:0]    cyc_o,
    input logic [1:0]                        mode_o,
    input logic [WIDTH-1:0]                  opa,
    input logic [WIDTH-1:0]                  opb,
    input logic                              busy
);

    localparam int NG = WIDTH / GRP;
    localparam int CW = $clog2(NG + 1);

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sum_o == opa + opb)); // R1

    AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_o) |-> !pipe_en_o); // R6

    AST_GATE_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in_i |-> !pipe_en_o); // R7

    AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !en_in_i) |=> (done_o && $stable(sum_o))); // R7

    AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(done_o && en_in_i)) |=> ($stable(opa) && $stable(opb))); // R8

    AST_REFUSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_o && start_i) |=> (cyc_o == $past(cyc_o) + 1'b1)); // R8

    AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_o <= CW'(NG)); // R5

    AST_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cyc_o == CW'(1)) |-> (mode_o == 2'd1)); // R9

    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (mode_o == 2'd0)); // R9

endmodule

bind seg_carry_adder seg_carry_adder_chk #(
    .WIDTH(WIDTH),
    .GRP  (GRP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .en_in_i   (en_in_i),
    .sum_o     (sum_o),
    .done_o    (done_o),
    .pipe_en_o (pipe_en_o),
    .cyc_o     (cyc_o),
    .mode_o    (mode_o),
    .opa       (opa_q),
    .opb       (opb_q),
    .busy      (busy)
);

// File: tb/test_seg_carry_adder.sv
`timescale 1ns/1ps
module test_seg_carry_adder;

    localparam int W = 64;
    localparam int K = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic         en_in;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] sum_o;
    logic         done_o;
    logic         pipe_en_o;
    logic [3:0]   cyc_o;
    logic [1:0]   mode_o;

    int total = 0;
    int bad   = 0;
    int seen1 = 0;
    int seen2 = 0;
    int seen3 = 0;

    always #4 clk = ~clk;

    seg_carry_adder #(.WIDTH(W), .GRP(K)) i_seg_carry_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .en_in_i   (en_in),
        .a_i       (a),
        .b_i       (b),
        .sum_o     (sum_o),
        .done_o    (done_o),
        .pipe_en_o (pipe_en_o),
        .cyc_o     (cyc_o),
        .mode_o    (mode_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // latency from the operand bits (see R3)
    function automatic int ref_lat(input logic [W-1:0] x, input logic [W-1:0] y);
        int last  = -1;
        int worst = 1;
        for (int i = 0; i < W; i++) begin
            int gi;
            int gj;
            gi = i / K;
            gj = (last < 0) ? -1 : last / K;
            if (gi - gj > worst) worst = gi - gj;
            if (x[i] == y[i]) last = i;
        end
        return worst;
    endfunction

    task automatic run_add(input logic [W-1:0] x, input logic [W-1:0] y, input int hold,
                           input bit refuse, input bit chain, input logic [W-1:0] nx,
                           input logic [W-1:0] ny, input bit loaded);
        int lat;
        int em;
        string tag;
        lat = ref_lat(x, y);
        em  = (lat == 1) ? 1 : (lat == 2) ? 2 : 3;
        tag = (lat == 1) ? "R3" : (lat == 2) ? "R4" : "R5";
        if (lat == 1) seen1++; else if (lat == 2) seen2++; else seen3++;
        if (!loaded) begin
            @(negedge clk);
            chk(pipe_en_o == 1'b1 && done_o == 1'b0, "R6 idle enable", W'(pipe_en_o), 1);
            chk(cyc_o == 4'd0, "R10 idle count", W'(cyc_o), 0);
            start = 1'b1;
            a = x;
            b = y;
        end
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            if (c == 1) chk(cyc_o == 4'd1, "R2 first cycle count", W'(cyc_o), 1);
            else        chk(cyc_o == 4'(c), "R9 cycle count", W'(cyc_o), W'(c));
            chk(done_o == (c == lat), tag, W'(done_o), W'(c == lat));
            chk(pipe_en_o == (c == lat), "R6 stall enable", W'(pipe_en_o), W'(c == lat));
            chk(mode_o == ((c == lat) ? 2'(em) : 2'd0), "R9 mode", W'(mode_o), (c == lat) ? W'(em) : 0);
            if (c == lat) chk(sum_o == x + y, "R1 sum", sum_o, x + y);
            start = 1'b0;
            if (refuse && c == 1 && lat > 1) begin
                start = 1'b1;   // R8: must be refused
                a = ~x;
                b = x ^ y;
            end
            if (c == lat && chain) begin
                start = 1'b1;
                a = nx;
                b = ny;
            end
            if (c == lat && hold > 0) en_in = 1'b0;
        end
        for (int h = 0; h < hold; h++) begin
            start = 1'b1;       // R7: no load while the enable is low
            a = ~x;
            b = ~y;
            @(negedge clk);
            chk(done_o == 1'b1, "R7 done held", W'(done_o), 1);
            chk(pipe_en_o == 1'b0, "R7 enable low", W'(pipe_en_o), 0);
            chk(sum_o == x + y, "R7 sum held", sum_o, x + y);
            chk(cyc_o == 4'(lat), "R7 count held", W'(cyc_o), W'(lat));
        end
        if (hold > 0) begin
            start = 1'b0;
            en_in = 1'b1;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        rst_n = 1'b0;
        start = 1'b0;
        en_in = 1'b1;
        a = '0;
        b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(done_o == 1'b0, "R10 done", W'(done_o), 0);
        chk(cyc_o == 4'd0, "R10 count", W'(cyc_o), 0);
        chk(mode_o == 2'd0, "R10 mode", W'(mode_o), 0);
        chk(pipe_en_o == en_in, "R10 enable", W'(pipe_en_o), W'(en_in));

        run_add('0, '0, 0, 0, 0, '0, '0, 0);                       // R3 all kill
        run_add('1, '1, 0, 0, 0, '0, '0, 0);                       // R3 all generate
        run_add(64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 0, 0, 0, '0, '0, 0);
        run_add(64'hFFFE_FFFE_FFFE_FFFE, '0, 0, 0, 0, '0, '0, 0);  // R4 two cycles
        run_add('1, '0, 0, 0, 0, '0, '0, 0);                       // R5 all propagate: m
        run_add('1, 64'h1, 0, 0, 0, '0, '0, 0);                    // R5 ripple from bit 0
        run_add('1, 64'h80, 0, 0, 0, '0, '0, 0);                   // R5
        run_add(64'hA5A5_0F0F_FFFF_0000, 64'h5A5A_F0F0_0000_FFFF, 0, 1, 0, '0, '0, 0); // R8 refuse
        run_add(64'hDEAD_BEEF_0000_1234, 64'h0000_0001_FFFF_0001, 3, 0, 0, '0, '0, 0); // R7 hold
        run_add('1, '0, 2, 0, 0, '0, '0, 0);                       // R7 hold after extended
        run_add(64'h77, 64'h19, 0, 0, 1, '1, '0, 0);               // R2 back-to-back start
        run_add('1, '0, 0, 1, 0, '0, '0, 1);

        for (int n = 0; n < 300; n++) begin
            int sel;
            sel = $urandom % 3;
            ra = {$urandom, $urandom};
            if (sel == 0) begin
                rb = {$urandom, $urandom};
            end else if (sel == 1) begin
                rb = ~ra ^ (W'(1) << ($urandom % W)) ^ (W'(1) << ($urandom % W));
            end else begin
                rb = ~ra;
                for (int q = 0; q < W; q += 2 * K) rb[q + ($urandom % K)] = ra[q + ($urandom % K)];
            end
            run_add(ra, rb, (n % 37 == 5) ? 1 : 0, (n % 11 == 3), 0, '0, '0, 0);
        end

        chk(seen1 > 0, "R3 normal mode seen", W'(seen1), 1);
        chk(seen2 > 0, "R4 sub-normal mode seen", W'(seen2), 1);
        chk(seen3 > 0, "R5 extended mode seen", W'(seen3), 1);
        @(negedge clk);
        finish_run();
    end

endmodule